// File: doc/BRIEF.md
# Protected Brown-Out Sleep-Disable Control Register

This block is one 8-bit control register on a simple memory-mapped port. Bit 6 is a protected bit. When it is set, it allows the brown-out detector to be switched off for the next sleep. Software cannot set this bit with a single write. It has to run a two-write unlock: first a write that sets bit 6 together with its enable at bit 5, and then, within a short window, a write with bit 6 set and bit 5 clear.

After the protected bit is set, it waits a few cycles before it takes effect. It then stays effective for a few cycles and clears itself. If a sleep request starts while the bit is effective, `bod_off` is raised and held for the whole of that sleep.

The remaining bits 7, 4, 1 and 0 are plain storage. Bits 3 and 2 are reserved.

Top module: `bodoff_ctl`

## Requirements
- R1: After reset, the register reads 0x00 and `bod_off` is 0.
- R2: Bits 7, 4, 1 and 0 hold the value last written to them. Bits 3 and 2 always read 0 and ignore writes. An access to any address other than `REG_ADDR` reads 0 and changes nothing.
- R3: A write with bits 6 and 5 both at 1 opens an unlock window of 4 cycles. While the window is open, bit 5 reads 1, and it reads 0 once the window has closed.
- R4: A write with bit 6 = 1 and bit 5 = 0, made 1 to 4 cycles after the opening write, sets bit 6, which reads 1 from the next cycle. The same write closes the window.
- R5: A completion write made 5 or more cycles after the opening write, or with no opening write before it, leaves bit 6 at 0. The plain bits are still updated by that write.
- R6: Any other write to the register while the window is open closes the window, so a following completion write leaves bit 6 at 0.
- R7: Once set, bit 6 reads 1 for 6 cycles and then clears by itself. Writes of 0 to bit 6 do not clear it early. It is effective from the 4th through the 6th of these cycles.
- R8: A rising `sleep_req` that is sampled while bit 6 is effective sets `bod_off` in the next cycle. `bod_off` stays high while `sleep_req` stays high and drops in the cycle after `sleep_req` is sampled low.
- R9: A sleep request that starts before bit 6 is effective, or after it has cleared, never raises `bod_off`. This holds even if bit 6 becomes effective while that request is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| sleep_req | input | 1 | Level sleep request |
| bod_off | output | 1 | Brown-out detector off for the current sleep |

## Verification
Two functions can fall in the same cycle, and the bench provokes both overlaps.

The first overlap is a completion write landing on the last open cycle of the unlock window. The bench runs the completion at every offset from 1 to 5 after the opening write and watches bit 5 and bit 6 at each step.

The second overlap is a sleep request starting during the effective period. The bench raises sleep before, during and after that period and holds each request while bit 6 counts down through its auto-clear. A cycle-level reference model built from the requirements judges `rdata` and `bod_off` on every clock. Literal checks at the edge cases back up the model.

// File: rtl/bodoff_ctl.sv
module bodoff_ctl #(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 32,
  parameter int WIN_LEN  = 4,
  parameter int EFF_DLY  = 3,
  parameter int EFF_LEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              sleep_req,
  output logic              bod_off
);
  localparam int TOTAL = EFF_DLY + EFF_LEN;
  localparam int CW    = $clog2(WIN_LEN + 1);
  localparam int AW    = $clog2(TOTAL + 1);

  logic [CW-1:0] win_cnt;
  logic [AW-1:0] age;
  logic [3:0]    plain;
  logic          sleep_q, bod_off_q;

  wire sel      = (addr == ADDR_W'(REG_ADDR));
  wire hit      = wr_en && sel;
  wire arm      = hit && wdata[6] && wdata[5];
  wire win_open = (win_cnt != '0);
  wire unlock   = hit && win_open && wdata[6] && !wdata[5];
  wire bods_on  = (age != '0);
  wire eff      = (age > AW'(EFF_DLY));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              win_cnt <= '0;
    else if (arm)            win_cnt <= CW'(WIN_LEN);
    else if (hit)            win_cnt <= '0;
    else if (win_open)       win_cnt <= win_cnt - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  age <= '0;
    else if (unlock)             age <= AW'(1);
    else if (age == AW'(TOTAL))  age <= '0;
    else if (bods_on)            age <= age + AW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   plain <= '0;
    else if (hit) plain <= {wdata[7], wdata[4], wdata[1], wdata[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sleep_q   <= 1'b0;
      bod_off_q <= 1'b0;
    end else begin
      sleep_q   <= sleep_req;
      bod_off_q <= sleep_req && (bod_off_q || (!sleep_q && eff));
    end

  assign rdata   = sel ? {plain[3], bods_on, win_open, plain[2], 2'b00, plain[1:0]} : 8'h00;
  assign bod_off = bod_off_q;
endmodule

module bodoff_ctl_chk #(
  parameter int WIN_LEN = 4,
  parameter int TOTAL   = 6,
  parameter int CW      = 3,
  parameter int AW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_req,
  input logic          bod_off,
  input logic          eff,
  input logic          bods_on,
  input logic          win_open,
  input logic [CW-1:0] win_cnt,
  input logic [AW-1:0] age,
  input logic [7:0]    rdata
);
  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n) rdata[3:2] == 2'b00);
  assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n) win_cnt <= CW'(WIN_LEN));
  assert_set_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bods_on) |-> $past(win_open));
  assert_autoclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bods_on) |-> $past(age) == AW'(TOTAL));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bod_off && sleep_req) |=> bod_off);
  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> !bod_off);
  assert_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bod_off) |-> ($past(eff) && $past(sleep_req)));
endmodule

bind bodoff_ctl bodoff_ctl_chk #(.WIN_LEN(WIN_LEN), .TOTAL(TOTAL), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bod_off(bod_off), .eff(eff),
  .bods_on(bods_on), .win_open(win_open), .win_cnt(win_cnt), .age(age), .rdata(rdata));

// File: tb/sim_bodoff_ctl.sv
module sim_bodoff_ctl;
  localparam int RA = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, sleep_req = 0;
  logic [7:0] addr = 8'(RA), wdata = 0;
  logic [7:0] rdata;
  logic bod_off;
  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  bodoff_ctl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                 .rdata(rdata), .sleep_req(sleep_req), .bod_off(bod_off));

  int m_win, m_age, m_sq, m_bo;
  logic [7:0] m_plain;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_age = 0; m_sq = 0; m_bo = 0; m_plain = 0;
    end else begin
      bit hit, open, eff;
      hit  = wr_en && addr == 8'(RA);
      open = m_win > 0;
      eff  = m_age > 3;
      m_bo = (sleep_req && (m_bo != 0 || (m_sq == 0 && eff))) ? 1 : 0;
      m_sq = sleep_req;
      if (m_age == 6) m_age = 0; else if (m_age > 0) m_age++;
      if (hit) begin
        m_plain = wdata & 8'h93;
        if (wdata[6] && wdata[5]) m_win = 4;
        else begin
          if (open && wdata[6]) m_age = 1;
          m_win = 0;
        end
      end else if (open) m_win--;
    end
  end

  function automatic logic [7:0] exp_rd();
    if (addr != 8'(RA)) return 8'h00;
    return m_plain | (m_age > 0 ? 8'h40 : 8'h00) | (m_win > 0 ? 8'h20 : 8'h00);
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #15;
    if (rst_n && !done) begin
      chk({tag, " model rdata"}, rdata, exp_rd());
      chk({tag, " model bod_off"}, {7'b0, bod_off}, 8'(m_bo));
    end
  end

  task automatic cyc(bit we, logic [7:0] d, bit slp);
    @(posedge clk); #5;
    wr_en = we; wdata = d; sleep_req = slp;
  endtask

  task automatic idle(int n, bit slp);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, slp);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    idle(1, 0);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset bod_off", {7'b0, bod_off}, 8'h00);

    tag = "R2";
    cyc(1, 8'h9F, 0); idle(1, 0);
    chk("R2 plain bits", rdata, 8'h93);
    addr = 8'(RA + 1);
    cyc(1, 8'h00, 0); idle(1, 0);
    chk("R2 other addr reads 0", rdata, 8'h00);
    addr = 8'(RA);
    #1 chk("R2 other addr write ignored", rdata, 8'h93);

    tag = "R3";
    cyc(1, 8'h60, 0); idle(1, 0);
    chk("R3 window open", rdata, 8'h20);
    idle(3, 0);
    chk("R3 window last cycle", rdata, 8'h20);
    idle(1, 0);
    chk("R3 window closed", rdata, 8'h00);

    for (int k = 1; k <= 4; k++) begin
      tag = "R4";
      cyc(1, 8'h60, 0); idle(k - 1, 0);
      cyc(1, 8'h40, 0); idle(1, 0);
      chk("R4 bods set at offset", rdata, 8'h40);
      idle(8, 0);
    end

    tag = "R7";
    cyc(1, 8'h60, 0); cyc(1, 8'h40, 0);
    idle(1, 0); cyc(1, 8'h01, 0);
    idle(4, 0);
    chk("R7 bods still set, no early clear", rdata, 8'h41);
    idle(1, 0);
    chk("R7 bods auto-cleared", rdata, 8'h01);

    tag = "R5";
    cyc(1, 8'h60, 0); idle(4, 0);
    cyc(1, 8'h40, 0); idle(1, 0);
    chk("R5 late completion", rdata, 8'h00);
    cyc(1, 8'h41, 0); idle(1, 0);
    chk("R5 no arm, plain bits updated", rdata, 8'h01);

    tag = "R6";
    cyc(1, 8'h60, 0); cyc(1, 8'h11, 0); idle(1, 0);
    chk("R6 window cancelled", rdata, 8'h11);
    cyc(1, 8'h40, 0); idle(1, 0);
    chk("R6 completion after cancel", rdata, 8'h00);
    idle(2, 0);

    tag = "R9";
    cyc(1, 8'h60, 0); cyc(1, 8'h40, 0);
    idle(1, 0); cyc(0, 8'h00, 1); idle(8, 1);
    chk("R9 sleep before effective", {7'b0, bod_off}, 8'h00);
    idle(3, 0);

    tag = "R8";
    cyc(1, 8'h60, 0); cyc(1, 8'h40, 0);
    idle(4, 0); cyc(0, 8'h00, 1); idle(1, 1);
    chk("R8 sleep during effective", {7'b0, bod_off}, 8'h01);
    idle(6, 1);
    chk("R8 held through sleep", {7'b0, bod_off}, 8'h01);
    cyc(0, 8'h00, 0); idle(1, 0);
    chk("R8 dropped after wake", {7'b0, bod_off}, 8'h00);
    idle(2, 0);

    tag = "R9";
    cyc(1, 8'h60, 0); cyc(1, 8'h40, 0);
    idle(7, 0); cyc(0, 8'h00, 1); idle(2, 1);
    chk("R9 sleep after auto-clear", {7'b0, bod_off}, 8'h00);
    idle(2, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule